// File: doc/BRIEF.md
# Auxiliary Address Register Unit

This block keeps a small file of pointer registers for a fixed-point signal processor and issues one data-memory address per cycle. When an access is requested, the selected pointer is presented unchanged on the address output. At the clock edge that closes the access, the pointer is rewritten according to a post-modify rule. The available rules are hold, a unit step, a step by an index, a step by an index that wraps inside a circular buffer, and a step by an index with the carry running from the most significant bit downward. Register 0 always supplies the index for the indexed rules.

The bit-reversed step does not use a reverse-carry ripple chain. Both operands are mirrored, added or subtracted with an ordinary parallel adder, and the result is mirrored back. This keeps the update path as short as a normal add. An immediate-load port writes a constant into any pointer. Circular buffers are described by a base address and a length supplied on input ports.

Top module: `aux_addr_unit`

## Requirements
- R1: Synchronous active-high reset clears every pointer register to zero.
- R2: While `access_en` is high, `addr_out` equals the selected pointer's value before modification and `next_value` shows the value after modification. The selected register takes `next_value` at the rising edge.
- R3: Mode code 0 (hold), and any code above 4, leave the selected pointer unchanged.
- R4: Mode code 1 adds 1 to the pointer, or subtracts 1 when `sub` is 1, modulo 2^W.
- R5: Mode code 2 adds the value of register 0 to the pointer, or subtracts it when `sub` is 1, modulo 2^W.
- R6: Mode code 3 steps the pointer by register 0 inside a circular buffer. On an add, a result at or above `circ_base + circ_len` has `circ_len` subtracted from it. On a subtract, a result below `circ_base` has `circ_len` added to it.
- R7: Mode code 4 steps by register 0 with the carry or borrow propagating from the MSB toward the LSB, modulo 2^W. With an index of 8 and a start of 0, the pointer runs 0, 8, 4, 12, 2, 10. Subtracting 8 from 0 gives 15. Adding 8 to 15 gives 0.
- R8: With `ld_en` high, `ld_value` is written into register `ld_sel` at the rising edge.
- R9: When a load and a post-modify target the same register in one cycle, the loaded value is kept. When they target different registers, both writes take effect.
- R10: With `access_en` low, no pointer is modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| access_en | input | 1 | Perform an indirect access with post-modify |
| sel | input | 3 | Pointer register used for the access |
| mode | input | 3 | Post-modify rule: 0 hold, 1 unit, 2 index, 3 circular, 4 bit-reversed |
| sub | input | 1 | 1 subtracts the step, 0 adds it |
| ld_en | input | 1 | Immediate-load enable |
| ld_sel | input | 3 | Register written by the immediate load |
| ld_value | input | 16 | Immediate value |
| circ_base | input | 16 | First address of the circular buffer |
| circ_len | input | 16 | Length of the circular buffer |
| addr_out | output | 16 | Address issued to data memory (current value of `sel`) |
| next_value | output | 16 | Post-modified value of the selected pointer |

## Verification
The hardest cases to reach are the wrap points: a circular step that lands exactly on the buffer end, a subtract that falls below the base, and a bit-reversed step whose reversed carry runs off the LSB. The bench reaches each one through the load port. It first plants a chosen index in register 0 and a chosen start in the pointer, then steps the pointer across the boundary and reads the register back through `addr_out`. The collision of a load with a post-modify on the same register is driven in a single cycle, together with a second case where the two target different registers.

// File: rtl/aru_pkg.sv
package aru_pkg;

    typedef enum logic [2:0] {
        PM_HOLD  = 3'd0,
        PM_UNIT  = 3'd1,
        PM_INDEX = 3'd2,
        PM_CIRC  = 3'd3,
        PM_BREV  = 3'd4
    } postmod_e;

    typedef struct packed {
        logic     en;
        postmod_e rule;
        logic     sub;
    } mod_req_t;

    function automatic postmod_e decode_rule(input logic [2:0] code);
        postmod_e r;
        case (code)
            3'd1:    r = PM_UNIT;
            3'd2:    r = PM_INDEX;
            3'd3:    r = PM_CIRC;
            3'd4:    r = PM_BREV;
            default: r = PM_HOLD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/aru_regfile.sv
module aru_regfile #(
    parameter int W = 16,
    parameter int N = 8,
    localparam int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] rd_sel,
    output logic [W-1:0]  rd_data,
    output logic [W-1:0]  idx_data,
    input  logic          upd_en,
    input  logic [SW-1:0] upd_sel,
    input  logic [W-1:0]  upd_data,
    input  logic          ld_en,
    input  logic [SW-1:0] ld_sel,
    input  logic [W-1:0]  ld_data
);
    logic [W-1:0] regs [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (ld_en && ld_sel == SW'(i))
                regs[i] <= ld_data;
            else if (upd_en && upd_sel == SW'(i))
                regs[i] <= upd_data;
        end
    end

    assign rd_data  = regs[rd_sel];
    assign idx_data = regs[0];
endmodule

// File: rtl/aru_brev_adder.sv
module aru_brev_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);
    logic [W-1:0] a_m, b_m, s_m;

    for (genvar i = 0; i < W; i++) begin : g_mirror
        assign a_m[i] = a[W-1-i];
        assign b_m[i] = b[W-1-i];
        assign y[i]   = s_m[W-1-i];
    end

    assign s_m = sub ? (a_m - b_m) : (a_m + b_m);
endmodule

// File: rtl/aru_modify.sv
module aru_modify
    import aru_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] idx,
    input  logic [W-1:0] base,
    input  logic [W-1:0] len,
    input  mod_req_t     req,
    output logic [W-1:0] nxt
);
    logic [W-1:0] brev_res;
    logic [W:0]   ext_sum, ext_dif, ext_end;
    logic [W-1:0] circ_res, unit_res, idx_res;

    aru_brev_adder #(.W(W)) u_brev (
        .a   (cur),
        .b   (idx),
        .sub (req.sub),
        .y   (brev_res)
    );

    always_comb begin
        ext_sum  = {1'b0, cur} + {1'b0, idx};
        ext_dif  = {1'b0, cur} - {1'b0, idx};
        ext_end  = {1'b0, base} + {1'b0, len};
        unit_res = req.sub ? cur - W'(1) : cur + W'(1);
        idx_res  = req.sub ? ext_dif[W-1:0] : ext_sum[W-1:0];
        if (!req.sub) begin
            if (ext_sum >= ext_end)
                circ_res = ext_sum[W-1:0] - len;
            else
                circ_res = ext_sum[W-1:0];
        end else begin
            if (ext_dif[W] || (ext_dif[W-1:0] < base))
                circ_res = ext_dif[W-1:0] + len;
            else
                circ_res = ext_dif[W-1:0];
        end
        case (req.rule)
            PM_UNIT:  nxt = unit_res;
            PM_INDEX: nxt = idx_res;
            PM_CIRC:  nxt = circ_res;
            PM_BREV:  nxt = brev_res;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/aux_addr_unit.sv
module aux_addr_unit
    import aru_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NREGS  = 8,
    localparam int SW = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              access_en,
    input  logic [SW-1:0]     sel,
    input  logic [2:0]        mode,
    input  logic              sub,
    input  logic              ld_en,
    input  logic [SW-1:0]     ld_sel,
    input  logic [ADDR_W-1:0] ld_value,
    input  logic [ADDR_W-1:0] circ_base,
    input  logic [ADDR_W-1:0] circ_len,
    output logic [ADDR_W-1:0] addr_out,
    output logic [ADDR_W-1:0] next_value
);
    mod_req_t          req;
    logic [ADDR_W-1:0] idx_val;

    assign req.en   = access_en;
    assign req.rule = decode_rule(mode);
    assign req.sub  = sub;

    aru_regfile #(.W(ADDR_W), .N(NREGS)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .rd_sel   (sel),
        .rd_data  (addr_out),
        .idx_data (idx_val),
        .upd_en   (req.en),
        .upd_sel  (sel),
        .upd_data (next_value),
        .ld_en    (ld_en),
        .ld_sel   (ld_sel),
        .ld_data  (ld_value)
    );

    aru_modify #(.W(ADDR_W)) u_mod (
        .cur  (addr_out),
        .idx  (idx_val),
        .base (circ_base),
        .len  (circ_len),
        .req  (req),
        .nxt  (next_value)
    );
endmodule

// File: rtl/aru_checker.sv
module aru_checker #(
    parameter int W  = 16,
    parameter int SW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          access_en,
    input logic [SW-1:0] sel,
    input logic [2:0]    mode,
    input logic          sub,
    input logic          ld_en,
    input logic [SW-1:0] ld_sel,
    input logic [W-1:0]  ld_value,
    input logic [W-1:0]  circ_base,
    input logic [W-1:0]  circ_len,
    input logic [W-1:0]  addr_out,
    input logic [W-1:0]  next_value,
    input logic [W-1:0]  idx
);
    logic [W:0] buf_end;
    assign buf_end = {1'b0, circ_base} + {1'b0, circ_len};

    // R2
    post_update_chk: assert property (@(posedge clk) disable iff (rst)
        (access_en && !(ld_en && ld_sel == sel))
        |=> (sel != $past(sel) || addr_out == $past(next_value)));

    // R8
    load_write_chk: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> (sel != $past(ld_sel) || addr_out == $past(ld_value)));

    // R3
    hold_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd0 || mode > 3'd4) |-> next_value == addr_out);

    // R4
    unit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd1) |-> next_value == (sub ? W'(addr_out - 1'b1) : W'(addr_out + 1'b1)));

    // R6
    circ_range_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd3 && circ_len != '0 && !buf_end[W] && idx <= circ_len
         && addr_out >= circ_base && {1'b0, addr_out} < buf_end)
        |-> (next_value >= circ_base && {1'b0, next_value} < buf_end));
endmodule

bind aux_addr_unit aru_checker #(.W(ADDR_W), .SW(SW)) u_aru_chk (
    .clk        (clk),
    .rst        (rst),
    .access_en  (access_en),
    .sel        (sel),
    .mode       (mode),
    .sub        (sub),
    .ld_en      (ld_en),
    .ld_sel     (ld_sel),
    .ld_value   (ld_value),
    .circ_base  (circ_base),
    .circ_len   (circ_len),
    .addr_out   (addr_out),
    .next_value (next_value),
    .idx        (idx_val)
);

// File: tb/aux_addr_unit_bench.sv
`timescale 1ns/1ps
module aux_addr_unit_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         access_en = 1'b0;
    logic [2:0]   sel = '0;
    logic [2:0]   mode = '0;
    logic         sub = 1'b0;
    logic         ld_en = 1'b0;
    logic [2:0]   ld_sel = '0;
    logic [W-1:0] ld_value = '0;
    logic [W-1:0] circ_base = 16'h0040;
    logic [W-1:0] circ_len = 16'h0008;
    logic [W-1:0] addr_out, next_value;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    aux_addr_unit u_aux_addr_unit (
        .clk(clk), .rst(rst), .access_en(access_en), .sel(sel), .mode(mode),
        .sub(sub), .ld_en(ld_en), .ld_sel(ld_sel), .ld_value(ld_value),
        .circ_base(circ_base), .circ_len(circ_len),
        .addr_out(addr_out), .next_value(next_value)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] r, output logic [W-1:0] v);
        @(negedge clk);
        access_en = 1'b0; ld_en = 1'b0; sel = r;
        #1 v = addr_out;
    endtask

    task automatic load(input logic [2:0] r, input logic [W-1:0] v);
        @(negedge clk);
        access_en = 1'b0; ld_en = 1'b1; ld_sel = r; ld_value = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic acc(input logic [2:0] r, input logic [2:0] m, input logic s,
                       output logic [W-1:0] a, output logic [W-1:0] n);
        @(negedge clk);
        access_en = 1'b1; sel = r; mode = m; sub = s;
        #1 a = addr_out; n = next_value;
        @(negedge clk);
        access_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [W-1:0] v;
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), v);
            check("R1 reset clears", v, '0);
        end
    endtask

    task automatic t_load_unit();
        logic [W-1:0] a, n, v;
        load(3'd3, 16'h1234);
        rd(3'd3, v); check("R8 load", v, 16'h1234);
        acc(3'd3, 3'd1, 1'b0, a, n);
        check("R2 address is old value", a, 16'h1234);
        check("R4 unit add", n, 16'h1235);
        rd(3'd3, v); check("R2 register updated", v, 16'h1235);
        acc(3'd3, 3'd1, 1'b1, a, n);
        rd(3'd3, v); check("R4 unit sub", v, 16'h1234);
        load(3'd7, 16'h0000);
        acc(3'd7, 3'd1, 1'b1, a, n);
        rd(3'd7, v); check("R4 unit wrap below zero", v, 16'hFFFF);
    endtask

    task automatic t_hold_idle();
        logic [W-1:0] a, n, v;
        acc(3'd3, 3'd0, 1'b0, a, n);
        rd(3'd3, v); check("R3 hold mode", v, 16'h1234);
        acc(3'd3, 3'd6, 1'b1, a, n);
        rd(3'd3, v); check("R3 unused code holds", v, 16'h1234);
        @(negedge clk);
        access_en = 1'b0; sel = 3'd3; mode = 3'd1; sub = 1'b0;
        @(negedge clk);
        #1 check("R10 no access no change", addr_out, 16'h1234);
    endtask

    task automatic t_index();
        logic [W-1:0] a, n, v;
        load(3'd0, 16'd5);
        load(3'd2, 16'd100);
        acc(3'd2, 3'd2, 1'b0, a, n);
        rd(3'd2, v); check("R5 index add", v, 16'd105);
        acc(3'd2, 3'd2, 1'b1, a, n);
        acc(3'd2, 3'd2, 1'b1, a, n);
        rd(3'd2, v); check("R5 index sub", v, 16'd95);
    endtask

    task automatic t_circ();
        logic [W-1:0] a, n, v;
        load(3'd0, 16'd3);
        load(3'd4, 16'h0046);
        acc(3'd4, 3'd3, 1'b0, a, n);
        rd(3'd4, v); check("R6 circular wrap past end", v, 16'h0041);
        acc(3'd4, 3'd3, 1'b1, a, n);
        rd(3'd4, v); check("R6 circular wrap below base", v, 16'h0046);
        load(3'd4, 16'h0045);
        acc(3'd4, 3'd3, 1'b0, a, n);
        rd(3'd4, v); check("R6 circular exact end", v, 16'h0040);
        load(3'd4, 16'h0042);
        acc(3'd4, 3'd3, 1'b0, a, n);
        rd(3'd4, v); check("R6 circular inside", v, 16'h0045);
    endtask

    task automatic t_brev();
        logic [W-1:0] a, n, v;
        logic [W-1:0] seq [5] = '{16'h0, 16'h8, 16'h4, 16'hC, 16'h2};
        load(3'd0, 16'd8);
        load(3'd5, 16'd0);
        for (int k = 0; k < 4; k++) begin
            acc(3'd5, 3'd4, 1'b0, a, n);
            check("R7 bitrev address", a, seq[k]);
            check("R7 bitrev next", n, seq[k+1]);
        end
        rd(3'd5, v); check("R7 bitrev register", v, 16'h2);
        load(3'd5, 16'hF);
        acc(3'd5, 3'd4, 1'b0, a, n);
        rd(3'd5, v); check("R7 bitrev wrap add", v, 16'h0);
        acc(3'd5, 3'd4, 1'b1, a, n);
        rd(3'd5, v); check("R7 bitrev sub", v, 16'hF);
    endtask

    task automatic t_collide();
        logic [W-1:0] v;
        load(3'd6, 16'h0100);
        @(negedge clk);
        access_en = 1'b1; sel = 3'd6; mode = 3'd1; sub = 1'b0;
        ld_en = 1'b1; ld_sel = 3'd6; ld_value = 16'h7777;
        @(negedge clk);
        access_en = 1'b0; ld_en = 1'b0;
        rd(3'd6, v); check("R9 load wins same register", v, 16'h7777);
        @(negedge clk);
        access_en = 1'b1; sel = 3'd6; mode = 3'd1; sub = 1'b0;
        ld_en = 1'b1; ld_sel = 3'd1; ld_value = 16'hABCD;
        @(negedge clk);
        access_en = 1'b0; ld_en = 1'b0;
        rd(3'd6, v); check("R9 update on other register", v, 16'h7778);
        rd(3'd1, v); check("R9 load on other register", v, 16'hABCD);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load_unit();
        t_hold_idle();
        t_index();
        t_circ();
        t_brev();
        t_collide();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule